// File: doc/BRIEF.md
# Hashed Exact-Match Flow Table

This block holds the per-flow state for reserved and multicast flows and finds it by an exact match on the full 5-tuple. The table has two separate regions, one for ingress and one for egress. Each region has a number of buckets, and each bucket has a small fixed number of ways. A lookup names its region and presents the key with the packet's length. The key is folded into a bucket index. All ways of that bucket are compared with the key in parallel. On a hit the block returns the stored forwarding data and bumps that entry's packet and byte counters in the same cycle.

The forwarding data has two output ports and two queue identifiers, so a multicast flow can feed two queues. It also has a rate value and a few flag bits. A management port installs, overwrites and removes entries in one or both regions in a single operation. It reports a one-cycle status for each operation. Bucket overflow is not chained: an install that finds every way of its bucket taken is refused.

Top module: `flow_match_table`

## Requirements
- R1: The key is `{src_addr[103:72], dst_addr[71:40], src_port[39:24], dst_port[23:8], proto[7:0]}`. The bucket index is the XOR of the key's thirteen 8-bit slices. Keys with equal folds share a bucket, and keys with different folds do not.
- R2: A lookup presented on `lk_valid` is answered on `res_valid` in the following cycle. `res_hit` is only ever high together with `res_valid`.
- R3: A lookup searches only the region named by `lk_egress` (0 = ingress, 1 = egress). An entry installed in one region is invisible to lookups in the other. The two regions keep separate data and counters for the same key.
- R4: A miss returns `res_hit` = 0 with every data and counter output zero.
- R5: A hit returns the entry's stored data. It returns the packet count incremented by one and the byte count incremented by `lk_len`, both as totals that include the current packet.
- R6: Lookups of the same entry in consecutive cycles each count their packet, with no update lost.
- R7: Each bucket holds two flows with colliding keys side by side. An install of a third colliding key returns status 1 (full) and changes nothing. Once a way is freed, the same install succeeds.
- R8: An install of a key already present in a region overwrites that entry's data and clears its counters, with status 0 (ok).
- R9: A remove clears the key from each selected region where it is present and returns status 0. If the key is absent from every selected region, it returns status 2 (absent).
- R10: A management operation with an empty region mask (`mg_regions` = 0; bit 0 ingress, bit 1 egress) returns status 3 and changes nothing.
- R11: Each management request on `mg_valid` is answered on `mg_done` in the following cycle with its status on `mg_status`.
- R12: When a lookup and a management operation on the same entry arrive in the same cycle, the lookup answers from the table as it was before the operation, and the operation's effect stands afterwards.
- R13: Reset (synchronous, active low) empties both regions, so every later lookup misses, and holds `res_valid` and `mg_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_egress | input | 1 | Region searched: 0 ingress, 1 egress |
| lk_key | input | 104 | 5-tuple key |
| lk_len | input | LEN_W (16) | Packet length in bytes |
| res_valid | output | 1 | Lookup answer present |
| res_hit | output | 1 | Key found |
| res_port0 | output | 4 | First output port |
| res_port1 | output | 4 | Second output port |
| res_qid0 | output | 10 | First queue identifier |
| res_qid1 | output | 10 | Second queue identifier |
| res_rate | output | 16 | Rate value |
| res_flags | output | 4 | Flag bits |
| res_pkts | output | 32 | Packet count including this packet |
| res_bytes | output | 48 | Byte count including this packet |
| mg_valid | input | 1 | Management request |
| mg_remove | input | 1 | 0 install, 1 remove |
| mg_regions | input | 2 | Region mask: bit 0 ingress, bit 1 egress |
| mg_key | input | 104 | Key to install or remove |
| mg_port0 | input | 4 | First output port to store |
| mg_port1 | input | 4 | Second output port to store |
| mg_qid0 | input | 10 | First queue identifier to store |
| mg_qid1 | input | 10 | Second queue identifier to store |
| mg_rate | input | 16 | Rate value to store |
| mg_flags | input | 4 | Flag bits to store |
| mg_done | output | 1 | Management answer present |
| mg_status | output | 2 | 0 ok, 1 full, 2 absent, 3 empty mask |

## Verification
The bench fills one bucket with three keys whose folds collide. A wrong fold would spread them over several buckets and accept the third install instead of refusing it. It repeats lookups of one entry in adjacent cycles, where a stale read-modify-write would report a count of 1 twice. It stores the same key in both regions and reads each copy back, which exposes a design that shares counters or ignores the region bit. It overwrites a live entry, which must show new data and restarted counts. It frees a way and refills it, and it issues a lookup and a remove of the same entry in one cycle: the lookup must still hit, and the entry must be gone on the next lookup.

// File: rtl/fmt_pkg.sv
// Shared formats of the flow table: key width, stored data fields,
// counters and management status codes. Assumes a 104-bit 5-tuple key.
package fmt_pkg;
    localparam int KEY_W   = 104;
    localparam int PORT_W  = 4;
    localparam int QID_W   = 10;
    localparam int RATE_W  = 16;
    localparam int FLAG_W  = 4;
    localparam int PKT_W   = 32;
    localparam int BYTE_W  = 48;
    localparam int NREGION = 2;

    typedef logic [KEY_W-1:0] key_t;

    typedef struct packed {
        logic [PORT_W-1:0] port0;
        logic [PORT_W-1:0] port1;
        logic [QID_W-1:0]  qid0;
        logic [QID_W-1:0]  qid1;
        logic [RATE_W-1:0] rate;
        logic [FLAG_W-1:0] flags;
    } fdata_t;

    typedef struct packed {
        key_t   key;
        fdata_t data;
    } fentry_t;

    typedef struct packed {
        logic [PKT_W-1:0]  pkts;
        logic [BYTE_W-1:0] bytes;
    } fcnt_t;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_FULL     = 2'd1,
        ST_ABSENT   = 2'd2,
        ST_NOREGION = 2'd3
    } mstat_t;
endpackage

// File: rtl/fmt_key_hash.sv
// Folds a wide key into a bucket index by XOR of consecutive IDX_W-bit
// slices; the top slice is zero-padded when KEY_W is not a multiple.
// Purely combinational.
module fmt_key_hash #(
    parameter int KEY_W = 104,
    parameter int IDX_W = 8
) (
    input  logic [KEY_W-1:0] key,
    output logic [IDX_W-1:0] bucket
);
    localparam int NCHUNK = (KEY_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = NCHUNK * IDX_W;

    logic [PAD_W-1:0] padded;

    // Zero-extend the key to a whole number of slices.
    assign padded = PAD_W'(key);

    // XOR all slices together.
    always_comb begin
        bucket = '0;
        for (int c = 0; c < NCHUNK; c++) begin
            bucket = bucket ^ padded[c*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/fmt_first_pick.sv
// Lowest-index selector: reports whether any request bit is set and the
// index of the lowest one. Assumes N >= 1.
module fmt_first_pick #(
    parameter int N    = 2,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    output logic            found,
    output logic [IDXW-1:0] idx
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/fmt_way_store.sv
// Storage for one way across both regions: valid bits, key+data and
// counters, addressed by {region, bucket}. One full read port serves
// lookups and NREGION key-only ports serve management. Writes happen at
// the clock edge. A management write to an address overrides a counter
// update to the same address in that cycle. Only valid bits are reset.
module fmt_way_store
    import fmt_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    // lookup read port
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_vld,
    output fentry_t           lk_ent,
    output fcnt_t             lk_cnt,
    // management key ports, one per region
    input  logic [ADDR_W-1:0] mg_addr [NREGION],
    output logic              mg_vld  [NREGION],
    output key_t              mg_kout [NREGION],
    // counter write from a hit
    input  logic              cnt_we,
    input  fcnt_t             cnt_val,
    // management writes
    input  logic [NREGION-1:0] mg_we,
    input  logic              mg_ins,
    input  fentry_t           mg_ent
);
    localparam int DEPTH = 1 << ADDR_W;

    logic    valid_q [DEPTH];
    fentry_t ent_q   [DEPTH];
    fcnt_t   cnt_q   [DEPTH];

    // Read the lookup slot combinationally.
    always_comb begin
        lk_vld = valid_q[lk_addr];
        lk_ent = ent_q[lk_addr];
        lk_cnt = cnt_q[lk_addr];
    end

    // Read the management slots combinationally.
    always_comb begin
        for (int r = 0; r < NREGION; r++) begin
            mg_vld[r]  = valid_q[mg_addr[r]];
            mg_kout[r] = ent_q[mg_addr[r]].key;
        end
    end

    // Maintain valid bits: cleared by reset, set by install, cleared by remove.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) valid_q[a] <= 1'b0;
        end else begin
            for (int r = 0; r < NREGION; r++) begin
                if (mg_we[r]) valid_q[mg_addr[r]] <= mg_ins;
            end
        end
    end

    // Write counters from hits, then let installs overwrite entry and counters.
    always_ff @(posedge clk) begin
        if (cnt_we) cnt_q[lk_addr] <= cnt_val;
        for (int r = 0; r < NREGION; r++) begin
            if (mg_we[r] && mg_ins) begin
                ent_q[mg_addr[r]] <= mg_ent;
                cnt_q[mg_addr[r]] <= '0;
            end
        end
    end
endmodule

// File: rtl/flow_match_table.sv
// Hashed exact-match flow table with ingress and egress regions.
// Lookups take one cycle: the bucket is read, all ways are compared, and
// the answer is registered while the hit entry's counters are written
// back at the same edge, so a lookup in the next cycle sees the update.
// Management installs/removes in one or both regions per request. It is
// answered one cycle later. Assumes the table never holds a key twice in
// one region, which the install path guarantees.
module flow_match_table
    import fmt_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int WAYS  = 2,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_egress,
    input  logic [KEY_W-1:0]  lk_key,
    input  logic [LEN_W-1:0]  lk_len,
    output logic              res_valid,
    output logic              res_hit,
    output logic [PORT_W-1:0] res_port0,
    output logic [PORT_W-1:0] res_port1,
    output logic [QID_W-1:0]  res_qid0,
    output logic [QID_W-1:0]  res_qid1,
    output logic [RATE_W-1:0] res_rate,
    output logic [FLAG_W-1:0] res_flags,
    output logic [PKT_W-1:0]  res_pkts,
    output logic [BYTE_W-1:0] res_bytes,
    input  logic              mg_valid,
    input  logic              mg_remove,
    input  logic [NREGION-1:0] mg_regions,
    input  logic [KEY_W-1:0]  mg_key,
    input  logic [PORT_W-1:0] mg_port0,
    input  logic [PORT_W-1:0] mg_port1,
    input  logic [QID_W-1:0]  mg_qid0,
    input  logic [QID_W-1:0]  mg_qid1,
    input  logic [RATE_W-1:0] mg_rate,
    input  logic [FLAG_W-1:0] mg_flags,
    output logic              mg_done,
    output logic [1:0]        mg_status
);
    localparam int ADDR_W = IDX_W + 1;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

    // ---------------- addressing ----------------
    logic [IDX_W-1:0]  lk_bucket, mg_bucket;
    logic [ADDR_W-1:0] lk_addr;
    logic [ADDR_W-1:0] mg_addr [NREGION];

    fmt_key_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_lk_hash (
        .key(lk_key), .bucket(lk_bucket)
    );
    fmt_key_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_mg_hash (
        .key(mg_key), .bucket(mg_bucket)
    );

    assign lk_addr = {lk_egress, lk_bucket};

    for (genvar r = 0; r < NREGION; r++) begin : g_mg_addr
        assign mg_addr[r] = {1'(r), mg_bucket};
    end

    // ---------------- per-way storage and compare ----------------
    logic [WAYS-1:0]    lk_match;
    fentry_t            lk_ent_w [WAYS];
    fcnt_t              lk_cnt_w [WAYS];
    logic [WAYS-1:0]    mg_match [NREGION];
    logic [WAYS-1:0]    mg_free  [NREGION];
    logic [NREGION-1:0] mg_we_w  [WAYS];
    logic [WAYS-1:0]    cnt_we_w;
    fcnt_t              cnt_next;
    fentry_t            mg_entry;

    assign mg_entry.key        = mg_key;
    assign mg_entry.data.port0 = mg_port0;
    assign mg_entry.data.port1 = mg_port1;
    assign mg_entry.data.qid0  = mg_qid0;
    assign mg_entry.data.qid1  = mg_qid1;
    assign mg_entry.data.rate  = mg_rate;
    assign mg_entry.data.flags = mg_flags;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic    lk_vld;
        fentry_t lk_ent;
        fcnt_t   lk_cnt;
        logic    mg_vld  [NREGION];
        key_t    mg_kout [NREGION];

        fmt_way_store #(.ADDR_W(ADDR_W)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .lk_addr (lk_addr),
            .lk_vld  (lk_vld),
            .lk_ent  (lk_ent),
            .lk_cnt  (lk_cnt),
            .mg_addr (mg_addr),
            .mg_vld  (mg_vld),
            .mg_kout (mg_kout),
            .cnt_we  (cnt_we_w[w]),
            .cnt_val (cnt_next),
            .mg_we   (mg_we_w[w]),
            .mg_ins  (!mg_remove),
            .mg_ent  (mg_entry)
        );

        // Compare this way's lookup slot against the presented key.
        assign lk_match[w] = lk_vld && (lk_ent.key == lk_key);
        assign lk_ent_w[w] = lk_ent;
        assign lk_cnt_w[w] = lk_cnt;
        assign cnt_we_w[w] = lk_valid && lk_match[w];

        for (genvar r = 0; r < NREGION; r++) begin : g_rgn
            // Classify this way's slot in region r for management.
            assign mg_match[r][w] = mg_vld[r] && (mg_kout[r] == mg_key);
            assign mg_free[r][w]  = !mg_vld[r];
        end
    end

    // ---------------- lookup datapath ----------------
    logic             lk_hit;
    logic [WAY_W-1:0] hit_way;
    fentry_t          hit_ent;
    fcnt_t            hit_cnt;

    fmt_first_pick #(.N(WAYS), .IDXW(WAY_W)) u_hit_pick (
        .req(lk_match), .found(lk_hit), .idx(hit_way)
    );

    // Select the hit way's entry and advance its counters.
    always_comb begin
        hit_ent        = lk_ent_w[hit_way];
        hit_cnt        = lk_cnt_w[hit_way];
        cnt_next.pkts  = hit_cnt.pkts + PKT_W'(1);
        cnt_next.bytes = hit_cnt.bytes + BYTE_W'(lk_len);
    end

    // ---------------- management decision ----------------
    logic [NREGION-1:0] present, has_free;
    logic [WAY_W-1:0]   match_way [NREGION];
    logic [WAY_W-1:0]   free_way  [NREGION];
    logic [NREGION-1:0] room;
    logic               ins_full;
    mstat_t             mg_st;

    for (genvar r = 0; r < NREGION; r++) begin : g_pick
        fmt_first_pick #(.N(WAYS), .IDXW(WAY_W)) u_match_pick (
            .req(mg_match[r]), .found(present[r]), .idx(match_way[r])
        );
        fmt_first_pick #(.N(WAYS), .IDXW(WAY_W)) u_free_pick (
            .req(mg_free[r]), .found(has_free[r]), .idx(free_way[r])
        );
    end

    assign room     = present | has_free;
    assign ins_full = |(mg_regions & ~room);

    // Decide the status of the current management request.
    always_comb begin
        if (mg_regions == '0)        mg_st = ST_NOREGION;
        else if (!mg_remove)         mg_st = ins_full ? ST_FULL : ST_OK;
        else if (|(mg_regions & present)) mg_st = ST_OK;
        else                         mg_st = ST_ABSENT;
    end

    // Steer management writes to the matching or first free way per region.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            for (int r = 0; r < NREGION; r++) begin
                if (!mg_valid || !mg_regions[r]) begin
                    mg_we_w[w][r] = 1'b0;
                end else if (!mg_remove) begin
                    mg_we_w[w][r] = !ins_full &&
                        (present[r] ? (match_way[r] == WAY_W'(w))
                                    : (free_way[r]  == WAY_W'(w)));
                end else begin
                    mg_we_w[w][r] = present[r] && (match_way[r] == WAY_W'(w));
                end
            end
        end
    end

    // ---------------- registered answers ----------------
    // Register the lookup answer; misses return zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_port0 <= '0;
            res_port1 <= '0;
            res_qid0  <= '0;
            res_qid1  <= '0;
            res_rate  <= '0;
            res_flags <= '0;
            res_pkts  <= '0;
            res_bytes <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && lk_hit;
            if (lk_valid && lk_hit) begin
                res_port0 <= hit_ent.data.port0;
                res_port1 <= hit_ent.data.port1;
                res_qid0  <= hit_ent.data.qid0;
                res_qid1  <= hit_ent.data.qid1;
                res_rate  <= hit_ent.data.rate;
                res_flags <= hit_ent.data.flags;
                res_pkts  <= cnt_next.pkts;
                res_bytes <= cnt_next.bytes;
            end else begin
                res_port0 <= '0;
                res_port1 <= '0;
                res_qid0  <= '0;
                res_qid1  <= '0;
                res_rate  <= '0;
                res_flags <= '0;
                res_pkts  <= '0;
                res_bytes <= '0;
            end
        end
    end

    // Register the management answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mg_done   <= 1'b0;
            mg_status <= ST_OK;
        end else begin
            mg_done   <= mg_valid;
            mg_status <= mg_valid ? mg_st : ST_OK;
        end
    end
endmodule

// File: rtl/fmt_checker.sv
// Property checker for flow_match_table, attached by bind. Observes
// ports only. Properties that use $past wait one cycle after reset.
module fmt_checker
    import fmt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              mg_valid,
    input logic              mg_remove,
    input logic [NREGION-1:0] mg_regions,
    input logic              res_valid,
    input logic              res_hit,
    input logic [PORT_W-1:0] res_port0,
    input logic [PORT_W-1:0] res_port1,
    input logic [QID_W-1:0]  res_qid0,
    input logic [QID_W-1:0]  res_qid1,
    input logic [RATE_W-1:0] res_rate,
    input logic [FLAG_W-1:0] res_flags,
    input logic [PKT_W-1:0]  res_pkts,
    input logic [BYTE_W-1:0] res_bytes,
    input logic              mg_done,
    input logic [1:0]        mg_status
);
    logic armed;

    // Arm the history-based checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);

    assert_answer_follows_request_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        res_valid |-> $past(lk_valid));

    assert_no_spurious_answer_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(lk_valid) |-> !res_valid);

    assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_port0 == '0 && res_port1 == '0 &&
            res_qid0 == '0 && res_qid1 == '0 && res_rate == '0 &&
            res_flags == '0 && res_pkts == '0 && res_bytes == '0));

    assert_hit_counts_packet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (res_pkts != '0));

    assert_reply_follows_request_R11: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        mg_done |-> $past(mg_valid));

    assert_full_only_install_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (mg_done && mg_status == ST_FULL) |-> !$past(mg_remove));

    assert_absent_only_remove_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (mg_done && mg_status == ST_ABSENT) |-> $past(mg_remove));

    assert_empty_mask_status_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        mg_done |-> ((mg_status == ST_NOREGION) == ($past(mg_regions) == '0)));

    assert_reset_quiet_R13: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !mg_done));
endmodule

bind flow_match_table fmt_checker chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .mg_valid   (mg_valid),
    .mg_remove  (mg_remove),
    .mg_regions (mg_regions),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_port0  (res_port0),
    .res_port1  (res_port1),
    .res_qid0   (res_qid0),
    .res_qid1   (res_qid1),
    .res_rate   (res_rate),
    .res_flags  (res_flags),
    .res_pkts   (res_pkts),
    .res_bytes  (res_bytes),
    .mg_done    (mg_done),
    .mg_status  (mg_status)
);

// File: tb/flow_match_table_test.sv
// Self-checking bench: a vector table walked one cycle per entry, then
// directed reset and same-cycle tests.
module flow_match_table_test;
    import fmt_pkg::*;

    localparam int K_LOOK = 0;
    localparam int K_INS  = 1;
    localparam int K_DEL  = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               lk_valid = 1'b0;
    logic               lk_egress = 1'b0;
    logic [KEY_W-1:0]   lk_key = '0;
    logic [15:0]        lk_len = '0;
    logic               res_valid, res_hit;
    logic [PORT_W-1:0]  res_port0, res_port1;
    logic [QID_W-1:0]   res_qid0, res_qid1;
    logic [RATE_W-1:0]  res_rate;
    logic [FLAG_W-1:0]  res_flags;
    logic [PKT_W-1:0]   res_pkts;
    logic [BYTE_W-1:0]  res_bytes;
    logic               mg_valid = 1'b0;
    logic               mg_remove = 1'b0;
    logic [NREGION-1:0] mg_regions = '0;
    logic [KEY_W-1:0]   mg_key = '0;
    fdata_t             mg_d = '0;
    logic               mg_done;
    logic [1:0]         mg_status;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    flow_match_table uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_egress(lk_egress), .lk_key(lk_key), .lk_len(lk_len),
        .res_valid(res_valid), .res_hit(res_hit),
        .res_port0(res_port0), .res_port1(res_port1),
        .res_qid0(res_qid0), .res_qid1(res_qid1),
        .res_rate(res_rate), .res_flags(res_flags),
        .res_pkts(res_pkts), .res_bytes(res_bytes),
        .mg_valid(mg_valid), .mg_remove(mg_remove), .mg_regions(mg_regions),
        .mg_key(mg_key),
        .mg_port0(mg_d.port0), .mg_port1(mg_d.port1),
        .mg_qid0(mg_d.qid0), .mg_qid1(mg_d.qid1),
        .mg_rate(mg_d.rate), .mg_flags(mg_d.flags),
        .mg_done(mg_done), .mg_status(mg_status)
    );

    // Keys 0..2 differ only by equal values in the two lowest bytes, so their folds match (R1).
    function automatic key_t key_of(input int sel);
        key_t base = 104'h0A000001_C0A80002_1F90_0050_11;
        if (sel < 3) return base ^ key_t'(sel) ^ (key_t'(sel) << 8);
        return base ^ (key_t'(sel) << 40);
    endfunction

    function automatic fdata_t data_of(input int sel);
        fdata_t d;
        d.port0 = PORT_W'(sel);
        d.port1 = PORT_W'(15 - sel);
        d.qid0  = QID_W'(100 + sel);
        d.qid1  = QID_W'(512 + 3 * sel);
        d.rate  = RATE_W'(256 * sel + 7);
        d.flags = FLAG_W'(sel ^ 10);
        return d;
    endfunction

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  rgn;
        logic [3:0]  ksel;
        logic [3:0]  dsel;
        logic [15:0] len;
        logic        hit;
        logic [31:0] pkts;
        logic [47:0] bytes;
        logic [1:0]  st;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t mkv(input int kind, input int rgn, input int ksel,
                                 input int dsel, input int len, input int hit,
                                 input int pkts, input int bytes, input int st,
                                 input int req);
        vec_t v;
        v.kind = 2'(kind);  v.rgn = 2'(rgn);   v.ksel = 4'(ksel);
        v.dsel = 4'(dsel);  v.len = 16'(len);  v.hit = 1'(hit);
        v.pkts = 32'(pkts); v.bytes = 48'(bytes); v.st = 2'(st);
        v.req = 4'(req);
        return v;
    endfunction

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        mkv(K_LOOK, 0, 0, 0,    0, 0, 0,    0, 0, 4),  // R4 empty table misses
        mkv(K_INS,  3, 0, 0,    0, 0, 0,    0, 0, 3),  // R3 install in both regions
        mkv(K_INS,  1, 1, 1,    0, 0, 0,    0, 0, 7),  // R7 second colliding way
        mkv(K_INS,  1, 2, 2,    0, 0, 0,    0, 1, 7),  // R7 R1 third collision full
        mkv(K_LOOK, 0, 0, 0,  100, 1, 1,  100, 0, 5),  // R5 first hit
        mkv(K_LOOK, 0, 0, 0,   60, 1, 2,  160, 0, 6),  // R6 back-to-back hit
        mkv(K_LOOK, 1, 0, 0,   40, 1, 1,   40, 0, 3),  // R3 egress copy own counters
        mkv(K_LOOK, 1, 1, 1,    0, 0, 0,    0, 0, 3),  // R3 ingress-only key absent in egress
        mkv(K_LOOK, 0, 1, 1, 1500, 1, 1, 1500, 0, 7),  // R7 colliding neighbour hits
        mkv(K_LOOK, 0, 2, 2,    0, 0, 0,    0, 0, 7),  // R7 refused key not present
        mkv(K_INS,  1, 0, 5,    0, 0, 0,    0, 0, 8),  // R8 overwrite live entry
        mkv(K_LOOK, 0, 0, 5,   10, 1, 1,   10, 0, 8),  // R8 new data, counters restarted
        mkv(K_LOOK, 1, 0, 0,    2, 1, 2,   42, 0, 3),  // R3 egress copy untouched
        mkv(K_DEL,  1, 1, 1,    0, 0, 0,    0, 0, 9),  // R9 remove present key
        mkv(K_LOOK, 0, 1, 1,    0, 0, 0,    0, 0, 9),  // R9 removed key misses
        mkv(K_DEL,  1, 1, 1,    0, 0, 0,    0, 2, 9),  // R9 remove absent key
        mkv(K_INS,  1, 2, 2,    0, 0, 0,    0, 0, 7),  // R7 freed way accepts
        mkv(K_LOOK, 0, 2, 2,   64, 1, 1,   64, 0, 7),  // R7 refilled way hits
        mkv(K_INS,  0, 3, 3,    0, 0, 0,    0, 3, 10), // R10 empty mask
        mkv(K_LOOK, 0, 3, 3,    0, 0, 0,    0, 0, 10), // R10 nothing installed
        mkv(K_INS,  2, 3, 3,    0, 0, 0,    0, 0, 3),  // R3 egress-only install
        mkv(K_LOOK, 1, 3, 3,    5, 1, 1,    5, 0, 5),  // R5 egress hit
        mkv(K_DEL,  3, 0, 0,    0, 0, 0,    0, 0, 9),  // R9 remove from both regions
        mkv(K_LOOK, 1, 0, 0,    0, 0, 0,    0, 0, 9)   // R9 egress copy gone
    };

    task automatic check(input int req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic fdata_t res_data();
        fdata_t d;
        d.port0 = res_port0; d.port1 = res_port1;
        d.qid0 = res_qid0;   d.qid1 = res_qid1;
        d.rate = res_rate;   d.flags = res_flags;
        return d;
    endfunction

    // Drive one lookup (called at a negedge).
    task automatic drive_look(input bit egress, input int ksel, input int len);
        lk_valid = 1'b1; lk_egress = egress; lk_key = key_of(ksel); lk_len = 16'(len);
    endtask

    // Drive one management request (called at a negedge).
    task automatic drive_mg(input bit remove, input int rgn, input int ksel, input int dsel);
        mg_valid = 1'b1; mg_remove = remove; mg_regions = NREGION'(rgn);
        mg_key = key_of(ksel); mg_d = data_of(dsel);
    endtask

    task automatic idle();
        lk_valid = 1'b0; mg_valid = 1'b0;
    endtask

    task automatic check_look(input int req, input bit hit, input int dsel,
                              input logic [31:0] pkts, input logic [47:0] bytes);
        check(req, "res_valid", 128'(res_valid), 128'(1));
        check(req, "res_hit",   128'(res_hit),   128'(hit));
        check(req, "data",      128'(res_data()), hit ? 128'(data_of(dsel)) : 128'(0));
        check(req, "pkts",      128'(res_pkts),  128'(pkts));
        check(req, "bytes",     128'(res_bytes), 128'(bytes));
    endtask

    task automatic run_vec(input vec_t v);
        if (v.kind == 2'(K_LOOK)) drive_look(v.rgn[0], int'(v.ksel), int'(v.len));
        else drive_mg(v.kind == 2'(K_DEL), int'(v.rgn), int'(v.ksel), int'(v.dsel));
        @(negedge clk);
        idle();
        if (v.kind == 2'(K_LOOK)) begin
            check_look(int'(v.req), v.hit, int'(v.dsel), v.pkts, v.bytes);
        end else begin
            check(int'(v.req), "mg_done",   128'(mg_done),   128'(1));
            check(int'(v.req), "mg_status", 128'(mg_status), 128'(v.st));
            check(int'(v.req), "res_valid quiet", 128'(res_valid), 128'(0));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13 outputs quiet after reset
        check(13, "res_valid after reset", 128'(res_valid), 128'(0));
        check(13, "mg_done after reset",   128'(mg_done),   128'(0));
        check(13, "res_hit after reset",   128'(res_hit),   128'(0));

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R12 lookup and remove of the same entry in one cycle
        drive_look(1'b0, 2, 36);
        drive_mg(1'b1, 1, 2, 2);
        @(negedge clk);
        idle();
        check_look(12, 1'b1, 2, 32'd2, 48'd100);
        check(12, "mg_status same cycle", 128'(mg_status), 128'(ST_OK));
        drive_look(1'b0, 2, 1);
        @(negedge clk);
        idle();
        check_look(12, 1'b0, 0, 32'd0, 48'd0);

        // R2 no answer without a request
        @(negedge clk);
        check(2, "res_valid idle", 128'(res_valid), 128'(0));
        check(11, "mg_done idle", 128'(mg_done), 128'(0));

        // R13 reset mid-run empties the table
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive_look(1'b1, 3, 9);
        @(negedge clk);
        idle();
        check_look(13, 1'b0, 0, 32'd0, 48'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule